// File: doc/BRIEF.md
# Priority-Level Channel Arbiter with Burst Hold

This block decides which of several DMA channels is served next. Every channel presents a request bit and a software-programmed priority level. The arbiter compares the levels of all channels that are requesting. The highest level wins. If two or more requesting channels share the top level, the channel with the smallest index wins. The winner is given as a one-hot grant vector and as an encoded index, both qualified by a valid flag.

A grant is registered and kept until the served channel's burst is reported finished on `burst_done_i`. While a grant is held, changes on the request and level inputs have no effect on it. This holds even when a more urgent channel starts requesting. After the release, the arbiter stays idle for one cycle. In the next cycle it arbitrates again, using only the requests and levels present in that cycle.

In stream terms, `grant_valid_o` is the valid flag of the grant stream. There is no ready signal. The consumer applies back-pressure by not pulsing `burst_done_i`, which stretches the grant for as long as it needs. Requests are plain levels. A channel does not have to keep its request asserted while it holds the grant.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grant_o` is all zeros, `grant_valid_o` is 0 and `grant_idx_o` is 0.
- R2: Each channel's level is a 2-bit field. Channel i uses bits [2i+1:2i] of `level_i`. The codes are 3 = very high, 2 = high, 1 = medium and 0 = low. A requesting channel with a higher level always wins over a requesting channel with a lower level.
- R3: Among requesting channels that share the highest level present, the one with the lowest index wins.
- R4: When no grant is held and at least one request is present in a cycle, the grant for the winner of that cycle appears in the following cycle.
- R5: While a grant is held and `burst_done_i` is low, the grant and index do not change. This applies whatever the requests and levels do, including a higher-level request appearing and the granted request being withdrawn.
- R6: A `burst_done_i` pulse while a grant is held removes the grant in the next cycle. The following decision uses the requests and levels of that idle cycle.
- R7: With no grant held and no request present, the next cycle shows an all-zero grant, `grant_valid_o` low and index 0.
- R8: `grant_o` has at most one bit set. When `grant_valid_o` is high, the set bit is bit `grant_idx_o`.
- R9: A `burst_done_i` pulse while no grant is held has no effect.
- R10: The level of a channel that is not requesting plays no part in the decision. A granted channel was requesting in the deciding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_CH (8) | One request bit per channel |
| level_i | input | N_CH*LVL_W (16) | Packed per-channel priority levels |
| burst_done_i | input | 1 | Pulse: the granted burst has finished |
| grant_o | output | N_CH (8) | One-hot grant, all zeros when idle |
| grant_idx_o | output | IDX_W (3) | Encoded index of the granted channel |
| grant_valid_o | output | 1 | A grant is held |

## Verification
The bench builds the block with its default values: eight channels and 2-bit levels. With these values the comparison tree is a full three-stage tree with no padding leaves, so every comparator pairing is used. A seeded random phase covers mixes of all four levels on all eight channels. In that phase, release pulses arrive both during grants and while idle. Directed steps cover priority overtaking during a hold, withdrawal of the granted request, ties at the top level, and a very-high level on a silent channel.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    PRIO_LOW   = 2'd0,
    PRIO_MED   = 2'd1,
    PRIO_HIGH  = 2'd2,
    PRIO_VHIGH = 2'd3
  } prio_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned LVL_W = 2,
  localparam int unsigned IDX_W = dma_arb_pkg::idx_width(N_CH)
) (
  input  logic [N_CH-1:0]       req,
  input  logic [N_CH*LVL_W-1:0] level,
  output logic                  win_any,
  output logic [IDX_W-1:0]      win_idx
);
  localparam int unsigned NP = 1 << IDX_W;
  localparam int unsigned KW = LVL_W + 1;

  logic [KW-1:0]    node_key [1:2*NP-1];
  logic [IDX_W-1:0] node_idx [1:2*NP-1];

  for (genvar g = 0; g < NP; g++) begin : g_leaf
    if (g < N_CH) begin : g_real
      assign node_key[NP+g] = {req[g], level[g*LVL_W +: LVL_W]};
    end else begin : g_pad
      assign node_key[NP+g] = '0;
    end
    assign node_idx[NP+g] = IDX_W'(g);
  end

  for (genvar k = 1; k < NP; k++) begin : g_node
    logic right_wins;
    // strict compare: the left (lower index) child keeps ties
    assign right_wins  = node_key[2*k+1] > node_key[2*k];
    assign node_key[k] = right_wins ? node_key[2*k+1] : node_key[2*k];
    assign node_idx[k] = right_wins ? node_idx[2*k+1] : node_idx[2*k];
  end

  assign win_any = node_key[1][KW-1];
  assign win_idx = node_idx[1];

  always_comb begin
    if (win_any) begin
      for (int j = 0; j < N_CH; j++) begin
        if (req[j]) begin
          assert_level_order_R2: assert (node_key[1][LVL_W-1:0] >= level[j*LVL_W +: LVL_W]);
          if (node_key[1][LVL_W-1:0] == level[j*LVL_W +: LVL_W])
            assert_tie_low_R3: assert (int'(win_idx) <= j);
        end
      end
      assert_win_requests_R10: assert (req[win_idx]);
    end
  end
endmodule

// File: rtl/dma_arb_hold.sv
module dma_arb_hold #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pick_any,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             done,
  output logic             held_valid,
  output logic [IDX_W-1:0] held_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_idx   <= '0;
    end else if (held_valid) begin
      if (done) begin
        held_valid <= 1'b0;
        held_idx   <= '0;
      end
    end else if (pick_any) begin
      held_valid <= 1'b1;
      held_idx   <= pick_idx;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    held_valid && !done |=> held_valid && $stable(held_idx));
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    held_valid && done |=> !held_valid);
  assert_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !held_valid && pick_any |=> held_valid && held_idx == $past(pick_idx));
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !held_valid && !pick_any |=> !held_valid && held_idx == '0);
endmodule

// File: rtl/dma_arb_decode.sv
module dma_arb_decode #(
  parameter int unsigned N_CH = 8,
  localparam int unsigned IDX_W = dma_arb_pkg::idx_width(N_CH)
) (
  input  logic             valid,
  input  logic [IDX_W-1:0] idx,
  output logic [N_CH-1:0]  grant
);
  for (genvar g = 0; g < N_CH; g++) begin : g_bit
    assign grant[g] = valid && (idx == IDX_W'(g));
  end

  always_comb begin
    assert_onehot_R8: assert ($onehot0(grant));
    if (valid) assert_bit_match_R8: assert (grant[idx]);
    else       assert_idle_zero_R7: assert (grant == '0);
  end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int unsigned N_CH  = 8,
  parameter int unsigned LVL_W = 2,
  localparam int unsigned IDX_W = dma_arb_pkg::idx_width(N_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH-1:0]       req_i,
  input  logic [N_CH*LVL_W-1:0] level_i,
  input  logic                  burst_done_i,
  output logic [N_CH-1:0]       grant_o,
  output logic [IDX_W-1:0]      grant_idx_o,
  output logic                  grant_valid_o
);
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;

  dma_arb_pick #(.N_CH(N_CH), .LVL_W(LVL_W)) u_pick (
    .req     (req_i),
    .level   (level_i),
    .win_any (pick_any),
    .win_idx (pick_idx)
  );

  dma_arb_hold #(.IDX_W(IDX_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_any   (pick_any),
    .pick_idx   (pick_idx),
    .done       (burst_done_i),
    .held_valid (grant_valid_o),
    .held_idx   (grant_idx_o)
  );

  dma_arb_decode #(.N_CH(N_CH)) u_dec (
    .valid (grant_valid_o),
    .idx   (grant_idx_o),
    .grant (grant_o)
  );

  assert_granted_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o && (|req_i) |=> (grant_o & $past(req_i)) != '0);
  assert_done_idle_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid_o && !(|req_i) && burst_done_i |=> !grant_valid_o);
endmodule

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;
  import dma_arb_pkg::*;

  localparam int N_CH = 8;
  localparam int LVL_W = 2;
  localparam int IDX_W = 3;

  typedef struct {
    logic             valid;
    logic [IDX_W-1:0] idx;
    string            tag;
  } exp_t;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [N_CH-1:0]       req = '0;
  logic [N_CH*LVL_W-1:0] lvl = '0;
  logic                  done = 1'b0;
  logic [N_CH-1:0]       grant;
  logic [IDX_W-1:0]      gidx;
  logic                  gvalid;

  int n_checks = 0;
  int n_fail = 0;
  exp_t sb[$];
  logic             m_valid = 1'b0;
  logic [IDX_W-1:0] m_idx = '0;

  always #5 clk = ~clk;

  dma_prio_arbiter i_dma_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .level_i(lvl),
    .burst_done_i(done), .grant_o(grant), .grant_idx_o(gidx), .grant_valid_o(gvalid)
  );

  function automatic logic [N_CH*LVL_W-1:0] lv_set(logic [N_CH*LVL_W-1:0] b, int ch, prio_e p);
    b[ch*LVL_W +: LVL_W] = p;
    return b;
  endfunction

  // driver: apply one cycle of stimulus and push the expected result of the next edge
  task automatic step(input logic [N_CH-1:0] r, input logic [N_CH*LVL_W-1:0] l,
                      input logic d, input string tag);
    exp_t e;
    int best;
    @(negedge clk);
    req = r; lvl = l; done = d;
    if (m_valid) begin
      if (d) begin m_valid = 1'b0; m_idx = '0; end
    end else begin
      best = -1;
      for (int c = 0; c < N_CH; c++)
        if (r[c] && (best < 0 || l[c*LVL_W +: LVL_W] > l[best*LVL_W +: LVL_W])) best = c;
      if (best >= 0) begin m_valid = 1'b1; m_idx = IDX_W'(best); end
      else begin m_valid = 1'b0; m_idx = '0; end
    end
    e.valid = m_valid; e.idx = m_idx; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare after each rising edge
  initial begin
    exp_t e;
    logic [N_CH-1:0] eg;
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        eg = e.valid ? (N_CH'(1) << e.idx) : '0;
        n_checks++;
        if (gvalid !== e.valid || gidx !== e.idx || grant !== eg) begin
          n_fail++;
          $display("FAIL %s R8: valid=%b idx=%0d grant=%b expected valid=%b idx=%0d grant=%b",
                   e.tag, gvalid, gidx, grant, e.valid, e.idx, eg);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [N_CH*LVL_W-1:0] l;
    logic [N_CH*LVL_W-1:0] rl;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (grant !== '0 || gvalid !== 1'b0 || gidx !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: valid=%b idx=%0d grant=%b expected 0/0/0", gvalid, gidx, grant);
    end
    @(negedge clk); rst_n = 1'b1;

    step('0, '0, 1'b0, "R1 R7 idle");
    step('0, '0, 1'b1, "R9 done while idle");
    step('0, '0, 1'b0, "R7 idle");

    l = '0;
    l = lv_set(l, 0, PRIO_LOW);
    l = lv_set(l, 2, PRIO_MED);
    l = lv_set(l, 5, PRIO_VHIGH);
    step(8'b0010_0101, l, 1'b0, "R2 R4 higher level wins");
    step(8'hFF, lv_set(l, 1, PRIO_VHIGH), 1'b0, "R5 hold vs higher level");
    step(8'hFF, {N_CH{2'b11}}, 1'b0, "R5 hold all very high");
    step('0, l, 1'b0, "R5 hold after withdraw");
    step(8'b0000_0101, l, 1'b1, "R6 release");
    step(8'b0000_0101, l, 1'b0, "R6 rearbitrate");
    step(8'b0000_0101, l, 1'b1, "R6 release");

    l = {N_CH{PRIO_MED}};
    step(8'b1010_1000, l, 1'b0, "R3 tie lowest index");
    step(8'b1010_1000, l, 1'b1, "R6 release");
    step('0, l, 1'b1, "R9 done idle");

    l = {N_CH{PRIO_LOW}};
    l = lv_set(l, 7, PRIO_VHIGH);
    l = lv_set(l, 4, PRIO_LOW);
    step(8'b0001_0000, l, 1'b0, "R10 silent high level ignored");
    step(8'b1001_0000, l, 1'b1, "R6 release");
    step(8'b1001_0000, l, 1'b0, "R2 very high wins");
    step('0, l, 1'b1, "R6 release");

    for (int i = 0; i < 400; i++) begin
      rl = {$urandom(), $urandom()} ;
      step(N_CH'($urandom()), rl, ($urandom() % 3) == 0, "R2 R3 R5 R6 random");
    end
    step('0, '0, 1'b1, "R6 drain");
    step('0, '0, 1'b0, "R7 drain");
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule